// File: doc/BRIEF.md
# Register-Controlled Watchdog Countdown Timer

This block is a watchdog timer that a host drives through a byte-wide register port. A prescaler divides the system clock down to a coarse tick, 0.6 seconds in the target system, so a time in seconds converts to ticks as seconds×10/6. A 6-bit countdown is decremented once per tick. When the countdown runs out, the block raises a timeout flag and reloads itself.

If the countdown runs out a second time before software has either cleared that flag or written the kick register, the block requests a system reset for one clock. A separate reboot-inhibit bit can block that request. The timer comes out of reset halted, and the host must clear the halt bit before it runs.

The registers sit at these addresses:

| Address | Register | Layout |
|---|---|---|
| 0 | control | bit 3 is the halt bit |
| 1 | reload | bits [5:0] hold the reload value, bits [7:6] are spare |
| 2 | kick | write-only |
| 3 | configuration | bit 1 is the reboot-inhibit bit |
| 4 | status A | bit 0 is the timeout flag |
| 5 | status B | bit 0 is the second-expiry flag, bit 1 is the blocked flag |

All other bits read as 0. Reads are combinational from `addr`.

Top module: `wdt_core`

## Requirements
- R1: After reset the block reads as follows: control reads 0x08 (halted), reload reads 0x04, configuration reads 0x02 (reboot inhibited), both status registers read 0x00, and `rst_req` is low.
- R2: A write to the reload register (address 1) always stores bits [7:6]. It stores bits [5:0] only if their value lies in 4..63; a value of 0..3 leaves the stored field unchanged.
- R3: The stored reload value is always within 4..63.
- R4: Any write to the kick register (address 2) loads the countdown with the reload value L and restarts the prescaler. While the timer runs, the timeout flag becomes visible exactly (L+1)×TICK_CLKS clock edges after the kick edge.
- R5: Control bit 3 reads back the halt state actually applied. While it is 1, both the prescaler and the countdown are frozen, so a halt lasting H edges delays the expiry by exactly H edges. With the timer halted, no expiry ever occurs.
- R6: An expiry while the block is not armed sets status A bit 0, reloads the countdown and arms the block. It raises no reset request.
- R7: An expiry while the block is armed sets status B bit 0. If the reboot-inhibit bit is clear, it also drives `rst_req` high for exactly one clock, on the edge of that expiry. With no intervening kick or clear, this edge is 2(L+1)×TICK_CLKS edges after the kick.
- R8: While configuration bit 1 is set, an armed expiry produces no pulse on `rst_req` and sets status B bits 1 and 0.
- R9: Status A bit 0 is write-one-to-clear. Writing 0 to that bit has no effect. A clear written on the same edge as an expiry leaves the flag set.
- R10: Status B bits [1:0] are write-one-to-clear.
- R11: A kick, or a clear of status A bit 0, disarms the block, so the next expiry acts as a first expiry and raises no reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The countdown is exercised in four ways:

- **Free run from a kick.** The edge-exact position of the first and second expiries separates off-by-one errors in the prescaler and in the countdown.
- **Halt windows of random length and placement.** These check that the halt freezes both stages, not just one.
- **Kick or flag clear between expiries.** These tell the armed state apart from the visible flag.
- **Clear written on the expiry edge.** This pins down set-over-clear priority.

Random bytes written to the reload register, mixed with the rejected values 0..3, separate the range filter from plain storage of the spare bits.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int VAL_W    = 6;
    localparam int MIN_LOAD = 4;

    localparam logic [2:0] ADR_CTRL = 3'd0;
    localparam logic [2:0] ADR_LOAD = 3'd1;
    localparam logic [2:0] ADR_KICK = 3'd2;
    localparam logic [2:0] ADR_CFG  = 3'd3;
    localparam logic [2:0] ADR_STA  = 3'd4;
    localparam logic [2:0] ADR_STB  = 3'd5;

    localparam int HALT_BIT    = 3;
    localparam int INHIBIT_BIT = 1;

    typedef struct packed {
        logic [1:0]       spare;
        logic [VAL_W-1:0] load_val;
        logic             halt;
        logic             inhibit;
        logic             to_flag;
        logic             armed;
        logic             sec_flag;
        logic             blk_flag;
        logic             rst_pls;
    } wdt_regs_t;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int TICK_CLKS = 30_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_CLKS - 1);

    logic [PW-1:0] pre_d, pre_q;

    assign tick_o = run_i && !restart_i && (pre_q == LAST);

    always_comb begin
        pre_d = pre_q;
        if (restart_i) begin
            pre_d = '0;
        end else if (run_i) begin
            pre_d = (pre_q == LAST) ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // Halt freezes the prescaler.
    assert_halt_freezes_pre_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !restart_i) |=> $stable(pre_q));

    generate
        if (TICK_CLKS > 1) begin : g_restart_chk
            // A kick restarts the prescaler, so no tick follows it at once.
            assert_restart_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
                restart_i |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter logic [VAL_W-1:0] DEF_LOAD = 6'd4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             reload_i,
    input  logic [VAL_W-1:0] load_val_i,
    output logic             expire_o
);
    logic [VAL_W-1:0] cnt_d, cnt_q;

    assign expire_o = tick_i && !reload_i && (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        if (reload_i || expire_o) begin
            cnt_d = load_val_i;
        end else if (tick_i) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= DEF_LOAD;
        else        cnt_q <= cnt_d;
    end

    // Every expiry reloads the countdown with the reload value.
    assert_reload_on_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (cnt_q == $past(load_val_i)));

    // A kick loads the countdown.
    assert_kick_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter logic [VAL_W-1:0] DEF_LOAD = 6'd4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [2:0]       addr_i,
    input  logic [7:0]       wdata_i,
    input  logic             expire_i,
    output logic [7:0]       rdata_o,
    output logic             halt_o,
    output logic             kick_o,
    output logic [VAL_W-1:0] load_val_o,
    output logic             rst_req_o
);
    wdt_regs_t s_d, s_q;

    logic wr_ctrl, wr_load, wr_cfg, wr_sta, wr_stb;
    logic clr_to, second;

    assign wr_ctrl = wr_en_i && (addr_i == ADR_CTRL);
    assign wr_load = wr_en_i && (addr_i == ADR_LOAD);
    assign kick_o  = wr_en_i && (addr_i == ADR_KICK);
    assign wr_cfg  = wr_en_i && (addr_i == ADR_CFG);
    assign wr_sta  = wr_en_i && (addr_i == ADR_STA);
    assign wr_stb  = wr_en_i && (addr_i == ADR_STB);
    assign clr_to  = wr_sta && wdata_i[0];
    assign second  = expire_i && s_q.armed;

    always_comb begin
        s_d = s_q;
        if (wr_ctrl) s_d.halt = wdata_i[HALT_BIT];
        if (wr_cfg)  s_d.inhibit = wdata_i[INHIBIT_BIT];
        if (wr_load) begin
            s_d.spare = wdata_i[7:6];
            if (wdata_i[VAL_W-1:0] >= VAL_W'(MIN_LOAD)) s_d.load_val = wdata_i[VAL_W-1:0];
        end
        // Clears first; a flag that sets on the same edge wins.
        if (clr_to) s_d.to_flag = 1'b0;
        if (clr_to || kick_o) s_d.armed = 1'b0;
        if (wr_stb) begin
            if (wdata_i[0]) s_d.sec_flag = 1'b0;
            if (wdata_i[1]) s_d.blk_flag = 1'b0;
        end
        if (expire_i) begin
            s_d.to_flag = 1'b1;
            s_d.armed   = 1'b1;
        end
        if (second) begin
            s_d.sec_flag = 1'b1;
            if (s_q.inhibit) s_d.blk_flag = 1'b1;
        end
        s_d.rst_pls = second && !s_q.inhibit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.load_val <= DEF_LOAD;
            s_q.halt     <= 1'b1;
            s_q.inhibit  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADR_CTRL: rdata_o[HALT_BIT] = s_q.halt;
            ADR_LOAD: rdata_o = {s_q.spare, s_q.load_val};
            ADR_CFG:  rdata_o[INHIBIT_BIT] = s_q.inhibit;
            ADR_STA:  rdata_o[0] = s_q.to_flag;
            ADR_STB:  rdata_o[1:0] = {s_q.blk_flag, s_q.sec_flag};
            default:  rdata_o = '0;
        endcase
    end

    assign halt_o     = s_q.halt;
    assign load_val_o = s_q.load_val;
    assign rst_req_o  = s_q.rst_pls;

    assert_load_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.load_val >= VAL_W'(MIN_LOAD));

    assert_rst_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    assert_rst_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> !$past(s_q.inhibit));

    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> s_q.to_flag);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int               TICK_CLKS = 30_000_000,
    parameter logic [VAL_W-1:0] DEF_LOAD  = 6'd4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       rst_req
);
    logic             halt, kick, tick, expire;
    logic [VAL_W-1:0] load_val;

    wdt_regfile #(.DEF_LOAD(DEF_LOAD)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .expire_i(expire), .rdata_o(rdata), .halt_o(halt), .kick_o(kick),
        .load_val_o(load_val), .rst_req_o(rst_req)
    );

    wdt_prescaler #(.TICK_CLKS(TICK_CLKS)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_i(!halt), .restart_i(kick), .tick_o(tick)
    );

    wdt_counter #(.DEF_LOAD(DEF_LOAD)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .reload_i(kick),
        .load_val_i(load_val), .expire_o(expire)
    );

    // While halted, the countdown never expires.
    assert_halt_no_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !expire);
endmodule

// File: tb/sim_wdt_core.sv
module sim_wdt_core;
    localparam int CLK_PERIOD = 10;
    localparam int TICK = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       rst_req;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    wdt_core #(.TICK_CLKS(TICK), .DEF_LOAD(6'd4)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int first_exp(int l);
        return (l + 1) * TICK;
    endfunction

    function automatic logic [7:0] exp_load(logic [7:0] prev, logic [7:0] w);
        return {w[7:6], (w[5:0] >= 6'd4) ? w[5:0] : prev[5:0]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic watch(int n, output int hits, output int first);
        hits = 0; first = -1;
        for (int i = 1; i <= n; i++) begin
            step(1);
            if (rst_req) begin
                hits++;
                if (first < 0) first = i;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, model;
        int hits, first, d, l, a, h, rem;
        void'($urandom(32'h1d0c_5eed));
        d = first_exp(4);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); chk("R1 control", v, 8'h08);
        rd(3'd1, v); chk("R1 reload", v, 8'h04);
        rd(3'd3, v); chk("R1 config", v, 8'h02);
        rd(3'd4, v); chk("R1 status A", v, 8'h00);
        rd(3'd5, v); chk("R1 status B", v, 8'h00);
        chk("R1 rst_req", rst_req, 1'b0);

        // R2/R3 random and directed reload writes
        model = 8'h04;
        for (int i = 0; i < 28; i++) begin
            logic [7:0] w;
            w = (i % 4 == 0) ? {$urandom_range(3, 0)} [7:0] | 8'h80 : 8'($urandom);
            if (i == 1) w = 8'h43;
            if (i == 2) w = 8'h3F;
            wr(3'd1, w);
            model = exp_load(model, w);
            rd(3'd1, v);
            chk("R2 reload readback", v, model);
            chk("R3 value in range", (v[5:0] >= 6'd4), 1'b1);
        end

        // Run with L=4, inhibit off
        wr(3'd1, 8'h04);
        wr(3'd3, 8'h00);
        wr(3'd0, 8'h00);
        rd(3'd0, v); chk("R5 halt readback cleared", v, 8'h00);
        wr(3'd2, 8'h01);
        watch(d - 1, hits, first);
        rd(3'd4, v); chk("R4 no flag before expiry", v, 8'h00);
        watch(1, hits, first);
        rd(3'd4, v); chk("R4 flag at (L+1)*TICK", v, 8'h01);
        chk("R6 no reset on first expiry", hits, 0);
        watch(d, hits, first);
        chk("R7 one reset pulse", hits, 1);
        chk("R7 pulse edge 2(L+1)*TICK", first, d);
        rd(3'd5, v); chk("R7 status B second", v, 8'h01);
        wr(3'd5, 8'h03);
        rd(3'd5, v); chk("R10 status B cleared", v, 8'h00);

        // R11 kick disarms
        wr(3'd2, 8'h01);
        watch(d, hits, first);
        chk("R11 kick disarms", hits, 0);
        watch(d, hits, first);
        chk("R11 rearmed pulses", hits, 1);
        // R11 flag clear disarms
        wr(3'd4, 8'h01);
        watch(d + TICK, hits, first);
        chk("R11 clear disarms", hits, 0);
        rd(3'd4, v); chk("R6 flag set again", v, 8'h01);

        // R9 clear collision and write-zero
        wr(3'd4, 8'h01);
        wr(3'd2, 8'h01);
        step(d - 1);
        wr(3'd4, 8'h01);
        rd(3'd4, v); chk("R9 set beats clear", v, 8'h01);
        wr(3'd4, 8'hFE);
        rd(3'd4, v); chk("R9 write zero no effect", v, 8'h01);
        wr(3'd4, 8'h01);
        rd(3'd4, v); chk("R9 write one clears", v, 8'h00);

        // R8 inhibit
        wr(3'd3, 8'h02);
        wr(3'd5, 8'h03);
        wr(3'd2, 8'h01);
        watch(2 * d, hits, first);
        chk("R8 no pulse when inhibited", hits, 0);
        rd(3'd5, v); chk("R8 status B blocked", v, 8'h03);
        wr(3'd5, 8'h02);
        rd(3'd5, v); chk("R10 clear bit1 only", v, 8'h01);

        // R5/R4 random halt windows, random reload
        for (int it = 0; it < 8; it++) begin
            l = $urandom_range(15, 4);
            wr(3'd1, 8'(l));
            wr(3'd4, 8'h01);
            wr(3'd2, 8'h01);
            a = $urandom_range(first_exp(l) - 3, 0);
            h = $urandom_range(12, 1);
            step(a);
            wr(3'd0, 8'h08);
            rd(3'd0, v); chk("R5 halt readback", v, 8'h08);
            step(h);
            wr(3'd0, 8'h00);
            rem = first_exp(l) - (a + 1);
            step(rem - 1);
            rd(3'd4, v); chk("R5 halted window delays expiry", v, 8'h00);
            step(1);
            rd(3'd4, v); chk("R5 expiry after delay", v, 8'h01);
        end

        // R5 halted timer never expires
        wr(3'd0, 8'h08);
        wr(3'd4, 8'h01);
        wr(3'd2, 8'h01);
        step(3 * d);
        rd(3'd4, v); chk("R5 halted no expiry", v, 8'h00);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule